// File: doc/BRIEF.md
# Transmit and Receive FIFO Pair with Fill Levels and DMA Requests

This block sits between a bus-facing register port and a serial shift engine. It holds two FIFOs of data words, each `DW` bits wide and `DEPTH` entries deep. Software writes transmit words into one FIFO, and the shift engine pops them. The engine pushes received words into the other FIFO, and software reads them back through the same data register.

Software can read the fill count of each FIFO and a status word. It can also write two threshold registers and two DMA level registers. A threshold or DMA level write is kept only when the value is below the depth. Software can therefore find the depth by writing rising values until one fails to read back.

Two request outputs tell a DMA engine when there is room to refill the transmit side and when data is waiting on the receive side. Each request has its own enable bit. A separate interrupt unit uses the threshold outputs and the two error pulses. Dropping the controller enable empties both FIFOs.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty and both fill counts read 0. The thresholds, DMA levels and DMA enables read 0. The status word reads 0x000C when `engine_busy` is low. `tx_valid`, `tx_dma_req` and `rx_dma_req` are low, and `rx_ready` is high.
- R2: Words written with `reg_sel`=0 leave on `tx_data`, oldest first. `tx_valid` is high while the transmit FIFO holds a word. Each cycle in which `tx_pop` and `tx_valid` are both high removes one word.
- R3: Words pushed with `rx_push` while `rx_ready` is high come back in arrival order on `reg_rdata` when `reg_rd` is high with `reg_sel`=0. Each such read removes one word.
- R4: `reg_sel`=1 reads the transmit fill count and `reg_sel`=2 reads the receive fill count. Each count ranges from 0 to `DEPTH` and updates on the clock edge after a push or pop.
- R5: The status word at `reg_sel`=5 has these bits: bit 0 is `engine_busy`, bit 1 is transmit full, bit 2 is transmit empty, bit 3 is receive empty and bit 4 is receive full. All other bits are 0.
- R6: `reg_sel`=3 is the transmit threshold and `reg_sel`=4 is the receive threshold. A written value below `DEPTH` is stored and reads back. A value of `DEPTH` or more is not stored, and the old value stays.
- R7: `reg_sel`=7 is the transmit DMA level and `reg_sel`=8 is the receive DMA level. They follow the same storage rule as R6, and 0 is a legal value.
- R8: The DMA control register is at `reg_sel`=6: bit 0 enables receive requests and bit 1 enables transmit requests. `tx_dma_req` is high while bit 1 is set and the transmit count is at or below the transmit DMA level.
- R9: `rx_dma_req` is high while bit 0 of the DMA control register is set and the receive count is above the receive DMA level.
- R10: While `enable` is low, both FIFOs are emptied on every clock edge. Data writes are ignored and raise no error.
- R11: A data write to a full transmit FIFO leaves its contents unchanged. It raises `tx_ovf_err` for one cycle, starting at the clock edge after the write.
- R12: A data read from an empty receive FIFO returns 0 and leaves the count at 0. It raises `rx_unf_err` for one cycle, starting at the clock edge after the read.
- R13: `rx_ready` is low while the receive FIFO is full, and a push in that state is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; low empties both FIFOs |
| engine_busy | input | 1 | Busy indication from the shift engine, reported in status bit 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_sel` |
| tx_pop | input | 1 | Shift engine takes the head transmit word |
| tx_valid | output | 1 | Transmit FIFO holds at least one word |
| tx_data | output | DW | Head transmit word |
| rx_push | input | 1 | Shift engine offers a received word |
| rx_wdata | input | DW | Received word |
| rx_ready | output | 1 | Receive FIFO has room |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_thresh | output | $clog2(DEPTH) | Stored transmit threshold, for the interrupt unit |
| rx_thresh | output | $clog2(DEPTH) | Stored receive threshold, for the interrupt unit |
| tx_ovf_err | output | 1 | One-cycle pulse after a write to a full transmit FIFO |
| rx_unf_err | output | 1 | One-cycle pulse after a read from an empty receive FIFO |

## Verification
The bench runs the transmit side three ways:
- A short burst shows that ordering and the fill count follow each word.
- A burst that fills the FIFO and then overruns it shows that the extra word is refused rather than overwriting the oldest one.
- A later refill checks that the pointers wrapped correctly.

The receive side is pushed below capacity and then past capacity, and is also read while empty, to separate dropped words from lost order.

The threshold and DMA level registers are written with values just below, at and above the depth, so that the store rule shows up at its edge. The DMA requests are tried at fill counts on both sides of each level, with the enables on and off.

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     engine_busy,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [3:0]               reg_sel,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic                     tx_pop,
  output logic                     tx_valid,
  output logic [DW-1:0]            tx_data,
  input  logic                     rx_push,
  input  logic [DW-1:0]            rx_wdata,
  output logic                     rx_ready,
  output logic                     tx_dma_req,
  output logic                     rx_dma_req,
  output logic [$clog2(DEPTH)-1:0] tx_thresh,
  output logic [$clog2(DEPTH)-1:0] rx_thresh,
  output logic                     tx_ovf_err,
  output logic                     rx_unf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);

  localparam logic [3:0] SEL_DATA   = 4'd0;
  localparam logic [3:0] SEL_TXLVL  = 4'd1;
  localparam logic [3:0] SEL_RXLVL  = 4'd2;
  localparam logic [3:0] SEL_TXTHR  = 4'd3;
  localparam logic [3:0] SEL_RXTHR  = 4'd4;
  localparam logic [3:0] SEL_STAT   = 4'd5;
  localparam logic [3:0] SEL_DMACTL = 4'd6;
  localparam logic [3:0] SEL_TXDLVL = 4'd7;
  localparam logic [3:0] SEL_RXDLVL = 4'd8;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [AW-1:0] tx_dlvl, rx_dlvl;
  logic [1:0]    dma_en;

  wire data_wr  = reg_wr && (reg_sel == SEL_DATA);
  wire data_rd  = reg_rd && (reg_sel == SEL_DATA);
  wire tx_full  = (tx_cnt == FULL_CNT);
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL_CNT);
  wire rx_empty = (rx_cnt == '0);
  wire cfg_ok   = (32'(reg_wdata) < DEPTH);

  wire tx_put  = enable && data_wr && !tx_full;
  wire tx_take = enable && tx_pop && !tx_empty;
  wire rx_put  = enable && rx_push && !rx_full;
  wire rx_take = enable && data_rd && !rx_empty;

  assign tx_valid   = !tx_empty;
  assign tx_data    = tx_mem[tx_rp];
  assign rx_ready   = !rx_full;
  assign tx_dma_req = dma_en[1] && (tx_cnt <= LW'(tx_dlvl));
  assign rx_dma_req = dma_en[0] && (rx_cnt > LW'(rx_dlvl));

  always_ff @(posedge clk) begin
    if (tx_put) tx_mem[tx_wp] <= reg_wdata;
    if (rx_put) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_put)  tx_wp <= tx_wp + 1'b1;
      if (tx_take) tx_rp <= tx_rp + 1'b1;
      if (tx_put && !tx_take)      tx_cnt <= tx_cnt + 1'b1;
      else if (tx_take && !tx_put) tx_cnt <= tx_cnt - 1'b1;
      if (rx_put)  rx_wp <= rx_wp + 1'b1;
      if (rx_take) rx_rp <= rx_rp + 1'b1;
      if (rx_put && !rx_take)      rx_cnt <= rx_cnt + 1'b1;
      else if (rx_take && !rx_put) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thresh <= '0; rx_thresh <= '0;
      tx_dlvl <= '0; rx_dlvl <= '0; dma_en <= '0;
      tx_ovf_err <= 1'b0; rx_unf_err <= 1'b0;
    end else begin
      tx_ovf_err <= enable && data_wr && tx_full;
      rx_unf_err <= enable && data_rd && rx_empty;
      if (reg_wr) begin
        if (reg_sel == SEL_TXTHR  && cfg_ok) tx_thresh <= reg_wdata[AW-1:0];
        if (reg_sel == SEL_RXTHR  && cfg_ok) rx_thresh <= reg_wdata[AW-1:0];
        if (reg_sel == SEL_TXDLVL && cfg_ok) tx_dlvl   <= reg_wdata[AW-1:0];
        if (reg_sel == SEL_RXDLVL && cfg_ok) rx_dlvl   <= reg_wdata[AW-1:0];
        if (reg_sel == SEL_DMACTL)           dma_en    <= reg_wdata[1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_DATA:   reg_rdata = rx_take ? rx_mem[rx_rp] : '0;
      SEL_TXLVL:  reg_rdata = DW'(tx_cnt);
      SEL_RXLVL:  reg_rdata = DW'(rx_cnt);
      SEL_TXTHR:  reg_rdata = DW'(tx_thresh);
      SEL_RXTHR:  reg_rdata = DW'(rx_thresh);
      SEL_STAT:   reg_rdata = DW'({rx_full, rx_empty, tx_empty, tx_full, engine_busy});
      SEL_DMACTL: reg_rdata = DW'(dma_en);
      SEL_TXDLVL: reg_rdata = DW'(tx_dlvl);
      SEL_RXDLVL: reg_rdata = DW'(rx_dlvl);
      default:    reg_rdata = '0;
    endcase
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_CNT) && (rx_cnt <= FULL_CNT));

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_cnt == '0) && (rx_cnt == '0));

  a_r11_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reg_wr && reg_sel == SEL_DATA && tx_cnt == FULL_CNT && !tx_pop)
    |=> (tx_cnt == FULL_CNT) && $stable(tx_wp) && tx_ovf_err);

  a_r6_threshold_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_TXTHR && 32'(reg_wdata) >= DEPTH) |=> $stable(tx_thresh));

  a_r3_rx_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_push && rx_cnt < FULL_CNT && !(reg_rd && reg_sel == SEL_DATA))
    |=> rx_cnt == LW'($past(rx_cnt) + 1'b1));

  a_r12_empty_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reg_rd && reg_sel == SEL_DATA && rx_cnt == '0 && !rx_push)
    |=> rx_unf_err && (rx_cnt == '0));
endmodule

// File: tb/xfer_fifo_pair_bench.sv
module xfer_fifo_pair_bench;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic engine_busy = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic tx_pop = 1'b0;
  logic tx_valid;
  logic [DW-1:0] tx_data;
  logic rx_push = 1'b0;
  logic [DW-1:0] rx_wdata = '0;
  logic rx_ready, tx_dma_req, rx_dma_req, tx_ovf_err, rx_unf_err;
  logic [$clog2(DEPTH)-1:0] tx_thresh, rx_thresh;

  always #5 clk = ~clk;

  xfer_fifo_pair #(.DW(DW), .DEPTH(DEPTH)) u_xfer_fifo_pair (
    .clk(clk), .rst_n(rst_n), .enable(enable), .engine_busy(engine_busy),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_ready(rx_ready),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_ovf_err(tx_ovf_err), .rx_unf_err(rx_unf_err));

  int checks = 0, failures = 0;
  int tx_model = 0, rx_model = 0;
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];
  logic last_err;
  logic [DW-1:0] rd_val;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] sel, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    last_err = tx_ovf_err;
  endtask

  task automatic reg_read(input logic [3:0] sel, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    last_err = rx_unf_err;
  endtask

  task automatic tx_send(input logic [DW-1:0] w);
    reg_write(4'd0, w);
    if (enable && tx_model < DEPTH) begin txq.push_back(w); tx_model++; end
  endtask

  task automatic tx_drain(input int n);
    @(negedge clk); tx_pop = 1'b1;
    repeat (n) @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic rx_send(input logic [DW-1:0] w);
    @(negedge clk); rx_push = 1'b1; rx_wdata = w;
    @(negedge clk); rx_push = 1'b0;
    if (rx_model < DEPTH) begin rxq.push_back(w); rx_model++; end
  endtask

  task automatic rx_fetch(input string tag);
    logic [DW-1:0] exp;
    exp = rxq.pop_front(); rx_model--;
    reg_read(4'd0, rd_val);
    chk(rd_val == exp, tag, rd_val, exp);
  endtask

  // scoreboard monitor for the transmit side (R2)
  always @(posedge clk) begin
    if (rst_n && enable && tx_pop && tx_valid) begin
      if (txq.size() == 0) chk(1'b0, "R2 unexpected tx word", tx_data, 0);
      else begin
        logic [DW-1:0] e;
        e = txq.pop_front(); tx_model--;
        chk(tx_data == e, "R2 tx order", tx_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_read(4'd5, rd_val); chk(rd_val == 16'h000C, "R1 status", rd_val, 16'h000C);
    reg_read(4'd1, rd_val); chk(rd_val == 0, "R1 tx level", rd_val, 0);
    reg_read(4'd2, rd_val); chk(rd_val == 0, "R1 rx level", rd_val, 0);
    reg_read(4'd3, rd_val); chk(rd_val == 0, "R1 tx thresh", rd_val, 0);
    reg_read(4'd6, rd_val); chk(rd_val == 0, "R1 dma ctrl", rd_val, 0);
    chk({tx_valid, tx_dma_req, rx_dma_req, rx_ready} == 4'b0001, "R1 outputs",
        {tx_valid, tx_dma_req, rx_dma_req, rx_ready}, 4'b0001);

    enable = 1'b1;
    // R2/R4 short burst
    tx_send(16'h1111); tx_send(16'h2222); tx_send(16'h3333);
    reg_read(4'd1, rd_val); chk(rd_val == 3, "R4 tx level", rd_val, 3);
    chk(tx_valid == 1'b1, "R2 tx_valid", tx_valid, 1);
    tx_drain(3);
    reg_read(4'd1, rd_val); chk(rd_val == 0, "R4 tx level drained", rd_val, 0);
    chk(txq.size() == 0, "R2 all words seen", txq.size(), 0);

    // R5/R11 fill and overrun
    for (int i = 0; i < DEPTH; i++) tx_send(16'hA000 + 16'(i));
    engine_busy = 1'b1;
    reg_read(4'd5, rd_val); chk(rd_val == 16'h000B, "R5 status tx full busy", rd_val, 16'h000B);
    engine_busy = 1'b0;
    tx_send(16'hDEAD);
    chk(last_err == 1'b1, "R11 overflow pulse", last_err, 1);
    @(negedge clk);
    chk(tx_ovf_err == 1'b0, "R11 pulse one cycle", tx_ovf_err, 0);
    reg_read(4'd1, rd_val); chk(rd_val == DEPTH, "R11 level held", rd_val, DEPTH);
    tx_drain(DEPTH);
    chk(txq.size() == 0, "R11 contents intact", txq.size(), 0);
    tx_send(16'h5A5A); tx_drain(1);

    // R3 receive
    for (int i = 0; i < 5; i++) rx_send(16'hB000 + 16'(i));
    reg_read(4'd2, rd_val); chk(rd_val == 5, "R4 rx level", rd_val, 5);
    for (int i = 0; i < 5; i++) rx_fetch("R3 rx order");
    // R12 empty read
    reg_read(4'd0, rd_val);
    chk(rd_val == 0, "R12 empty read data", rd_val, 0);
    chk(last_err == 1'b1, "R12 underflow pulse", last_err, 1);
    reg_read(4'd2, rd_val); chk(rd_val == 0, "R12 rx level", rd_val, 0);

    // R13 receive overrun
    for (int i = 0; i < DEPTH + 1; i++) rx_send(16'hC000 + 16'(i));
    chk(rx_ready == 1'b0, "R13 rx_ready low", rx_ready, 0);
    reg_read(4'd5, rd_val); chk(rd_val == 16'h0014, "R5 status rx full", rd_val, 16'h0014);
    for (int i = 0; i < DEPTH; i++) rx_fetch("R13 rx kept words");
    reg_read(4'd2, rd_val); chk(rd_val == 0, "R13 extra dropped", rd_val, 0);

    // R6 thresholds
    reg_write(4'd3, 16'd5);  reg_read(4'd3, rd_val); chk(rd_val == 5, "R6 tx thresh", rd_val, 5);
    reg_write(4'd3, 16'd16); reg_read(4'd3, rd_val); chk(rd_val == 5, "R6 tx thresh at depth", rd_val, 5);
    reg_write(4'd3, 16'd15); reg_read(4'd3, rd_val); chk(rd_val == 15, "R6 tx thresh max", rd_val, 15);
    chk(tx_thresh == 15, "R6 tx thresh port", tx_thresh, 15);
    reg_write(4'd4, 16'd9);  reg_write(4'd4, 16'hFFFF);
    reg_read(4'd4, rd_val); chk(rd_val == 9, "R6 rx thresh", rd_val, 9);

    // R7/R8 transmit DMA
    reg_write(4'd7, 16'd2);  reg_write(4'd7, 16'd20);
    reg_read(4'd7, rd_val); chk(rd_val == 2, "R7 tx dma level", rd_val, 2);
    reg_write(4'd6, 16'd2);
    chk(tx_dma_req == 1'b1, "R8 tx req at 0", tx_dma_req, 1);
    tx_send(16'h0001); tx_send(16'h0002);
    chk(tx_dma_req == 1'b1, "R8 tx req at level", tx_dma_req, 1);
    tx_send(16'h0003);
    chk(tx_dma_req == 1'b0, "R8 tx req above level", tx_dma_req, 0);
    tx_drain(3);
    reg_write(4'd6, 16'd0);
    chk(tx_dma_req == 1'b0, "R8 tx req disabled", tx_dma_req, 0);

    // R7/R9 receive DMA with level 0
    reg_write(4'd8, 16'd0); reg_read(4'd8, rd_val); chk(rd_val == 0, "R7 rx dma level 0", rd_val, 0);
    reg_write(4'd6, 16'd1);
    chk(rx_dma_req == 1'b0, "R9 rx req empty", rx_dma_req, 0);
    rx_send(16'h7777);
    chk(rx_dma_req == 1'b1, "R9 rx req one word", rx_dma_req, 1);
    reg_write(4'd6, 16'd0);
    chk(rx_dma_req == 1'b0, "R9 rx req disabled", rx_dma_req, 0);

    // R10 disable clears
    tx_send(16'h4444); tx_send(16'h5555);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    txq.delete(); rxq.delete(); tx_model = 0; rx_model = 0;
    reg_read(4'd1, rd_val); chk(rd_val == 0, "R10 tx cleared", rd_val, 0);
    reg_read(4'd2, rd_val); chk(rd_val == 0, "R10 rx cleared", rd_val, 0);
    tx_send(16'h6666);
    chk(last_err == 1'b0, "R10 no error when disabled", last_err, 0);
    reg_read(4'd1, rd_val); chk(rd_val == 0, "R10 write ignored", rd_val, 0);
    enable = 1'b1;
    tx_send(16'h8888); tx_drain(1);
    chk(txq.size() == 0, "R10 fresh after enable", txq.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule